// File: doc/BRIEF.md
# Data TLB with Software Reload Assist

This block is a data-side address translation buffer that software refills by hand. It holds a fully associative set of translation entries. Each entry carries a virtual page number, an address-space tag, a page size, a real page number and a few storage attributes. A lookup port takes an effective address and the current address-space tag, and on a hit returns the index of the matching slot, the translated physical address and the stored attributes.

When a valid lookup misses, the walk state machine moves from `WS_READY` to `WS_PENDING`. On that move it latches the missing page number and the current tag into the page-number register. While pending, the block helps the miss handler locate page-table entries:

- A read of the first-level base register returns the first-level descriptor address.
- A read of the second-level control register returns the second-level descriptor address.

Both addresses are formed by mask-and-add from the latched page number. The handler then writes the control register to pick a slot and writes the second-level control word. Its final write, to the real-page register, assembles an entry from three sources and stores it: the page-number register, the second-level control word, and the written value. That write is the `commit` transition, and it takes the machine from `WS_PENDING` back to `WS_READY`. A miss seen in `WS_READY` is the `capture` transition. Any other cycle holds the current state.

Register selector `reg_addr`:

| Code | Register |
|------|----------|
| 0 | control |
| 1 | current tag |
| 2 | page number |
| 3 | first-level base |
| 4 | second-level control |
| 5 | real page |

Codes 6 and 7 read as zero.

Top module: `tlb_reload_unit`

## Requirements
- R1: After reset, the control register reads 0x0400_0000 (bit 26 is the assist enable), `walk_pending` is 0, and no lookup hits.
- R2: A register write is visible on `reg_rdata` from the next cycle. The current-tag register keeps only its 4 low bits and reads zero above them.
- R3: A write to the real-page register stores an entry into slot control[12:8]. The entry's virtual page comes from page-number bits 31:12 and its tag from bits 3:0. Its page size comes from second-level bits 3:2, its protection group from bits 8:5, guarded from bit 4 and write-through from bit 1. Its real page comes from the written bits 31:12. `lk_attr` is {group, guarded, write-through}.
- R4: An entry can hit only if page-number bit 9 and second-level bit 0 were both 1 at commit, and its tag equals the current tag.
- R5: Size code 11 (8 MB) ignores the low 11 page bits in the compare and takes physical bits 22:0 from the address. Code 01 (512 KB) ignores the low 7 and takes bits 18:0. Code 00 (4 KB) compares all 20 and takes bits 11:0.
- R6: When several entries match, `lk_idx` reports the lowest index.
- R7: A valid lookup that misses while `walk_pending` is 0 sets `walk_pending` next cycle. It also loads the page-number register with {address[31:12], 2'b00, 1, 5'b0, current tag}. Misses while pending leave that register unchanged.
- R8: A real-page write clears `walk_pending` in the next cycle.
- R9: A first-level base read returns {base[31:12], page[31:22], 2'b00}.
- R10: With control bit 26 set, a second-level read returns {word[31:12], 12'b0} + {page[21:12], 2'b00}. With bit 26 clear, it returns the stored word unchanged.
- R11: A lookup in the same cycle as a commit sees the slot's previous contents.
- R12: Committing to an occupied slot replaces it, so the old page no longer hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register selector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W (5) | Index of the hitting slot |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 6 | {protection group, guarded, write-through} of the hit |
| walk_pending | output | 1 | Miss latched, reload awaited |

## Verification
A corrupted slot shows up at the lookup port on the very next lookup of that page. The failure is a missing hit, a wrong index or a wrong physical address; neighbouring slots that were loaded with unrelated pages stay correct.

A wrong walk state shows up one cycle after the trigger. `walk_pending` either fails to rise on a miss or fails to drop on commit, and the page-number register reads back either a later miss address or a stale one.

A fault in the descriptor-address logic is visible at once on a combinational read of the two walk registers. The bench sweeps every slot with distinct pages, so a priority or indexing error lands on a specific, named slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W  = 20;
    localparam int TAG_W  = 4;
    localparam int OFF_W  = 12;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0400_0000;
    localparam int ASSIST_BIT = 26;
    localparam int IDX_LSB    = 8;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_TAG    = 3'd1,
        RA_PAGE   = 3'd2,
        RA_L1BASE = 3'd3,
        RA_L2CTRL = 3'd4,
        RA_RPAGE  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        PS_4K   = 2'b00,
        PS_512K = 2'b01,
        PS_RSVD = 2'b10,
        PS_8M   = 2'b11
    } pg_size_e;

    typedef enum logic {
        WS_READY   = 1'b0,
        WS_PENDING = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [VPN_W-1:0] vpn;
        pg_size_e         size;
        logic [3:0]       grp;
        logic             guarded;
        logic             wthru;
        logic [VPN_W-1:0] rpn;
    } tlb_entry_t;

    // Page-number bits that take part in the compare for a given size.
    function automatic logic [VPN_W-1:0] cmp_mask(pg_size_e sz);
        unique case (sz)
            PS_8M:   cmp_mask = {{(VPN_W-11){1'b1}}, 11'b0};
            PS_512K: cmp_mask = {{(VPN_W-7){1'b1}}, 7'b0};
            default: cmp_mask = {VPN_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/tlb_walk_regs.sv
module tlb_walk_regs
    import tlb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              miss,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic [TAG_W-1:0]  cur_tag,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output tlb_entry_t        commit_entry,
    output logic              pending
);

    logic [WORD_W-1:0] ctrl_q, page_q, l1_q, l2_q;
    logic [TAG_W-1:0]  tag_q;
    walk_state_e       state_q, state_d;
    logic              wr_page, capture;

    assign commit  = wr_en && (reg_sel_e'(addr) == RA_RPAGE);
    assign wr_page = wr_en && (reg_sel_e'(addr) == RA_PAGE);
    assign capture = (state_q == WS_READY) && miss;

    // walk state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_READY;
        else        state_q <= state_d;
    end

    // transitions: capture (miss in READY), commit (real-page write)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_READY:   if (miss && !commit) state_d = WS_PENDING;
            WS_PENDING: if (commit)          state_d = WS_READY;
            default:    state_d = WS_READY;
        endcase
    end

    // state-derived outputs
    always_comb begin
        unique case (state_q)
            WS_PENDING: pending = 1'b1;
            default:    pending = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            tag_q  <= '0;
            page_q <= '0;
            l1_q   <= '0;
            l2_q   <= '0;
        end else begin
            if (wr_en) begin
                unique case (reg_sel_e'(addr))
                    RA_CTRL:   ctrl_q <= wdata;
                    RA_TAG:    tag_q  <= wdata[TAG_W-1:0];
                    RA_L1BASE: l1_q   <= wdata;
                    RA_L2CTRL: l2_q   <= wdata;
                    default:   ;
                endcase
            end
            if (wr_page)
                page_q <= wdata;
            else if (capture)
                page_q <= {miss_vpn, 2'b00, 1'b1, 5'b0, tag_q};
        end
    end

    assign cur_tag    = tag_q;
    assign commit_idx = ctrl_q[IDX_LSB +: IDX_W];

    always_comb begin
        commit_entry.valid   = page_q[9] & l2_q[0];
        commit_entry.tag     = page_q[TAG_W-1:0];
        commit_entry.vpn     = page_q[WORD_W-1:OFF_W];
        commit_entry.size    = pg_size_e'(l2_q[3:2]);
        commit_entry.grp     = l2_q[8:5];
        commit_entry.guarded = l2_q[4];
        commit_entry.wthru   = l2_q[1];
        commit_entry.rpn     = wdata[WORD_W-1:OFF_W];
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            RA_CTRL:   rdata = ctrl_q;
            RA_TAG:    rdata = {{(WORD_W-TAG_W){1'b0}}, tag_q};
            RA_PAGE:   rdata = page_q;
            RA_L1BASE: rdata = {l1_q[WORD_W-1:OFF_W], page_q[31:22], 2'b00};
            RA_L2CTRL: rdata = ctrl_q[ASSIST_BIT]
                             ? ({l2_q[WORD_W-1:OFF_W], 12'b0} +
                                {20'b0, page_q[21:12], 2'b00})
                             : l2_q;
            default:   rdata = '0;
        endcase
    end

    // R8: a commit always ends a pending walk
    p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);

    // R7: the latched miss is held while pending unless software rewrites it
    p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !wr_page) |=> $stable(page_q));

    // R7: a miss in READY latches the missing page number
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && miss && !wr_page) |=> page_q[WORD_W-1:OFF_W] == $past(miss_vpn));

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output tlb_entry_t       hit_entry
);

    tlb_entry_t             ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ent_q[g] <= wr_entry;
        end

        assign match[g] = ent_q[g].valid
                       && (ent_q[g].tag == lk_tag)
                       && (((ent_q[g].vpn ^ lk_vpn) & cmp_mask(ent_q[g].size)) == '0);
    end

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = i[IDX_W-1:0];
            end
        end
    end

    assign hit_entry = ent_q[hit_idx];

    // R3: the addressed slot holds what was written
    p_slot_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)] == $past(wr_entry));

    // R6: no lower slot matches when a hit is reported
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match & ((NUM_ENTRIES'(1) << hit_idx) - NUM_ENTRIES'(1))) == '0);

    // R4: a reported hit is backed by a valid entry with the right tag
    p_hit_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_entry.valid && hit_entry.tag == lk_tag));

endmodule

// File: rtl/tlb_reload_unit.sv
module tlb_reload_unit
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             lk_valid,
    input  logic [31:0]      lk_ea,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [31:0]      lk_pa,
    output logic [5:0]       lk_attr,
    output logic             walk_pending
);

    logic             commit, raw_hit;
    logic [IDX_W-1:0] commit_idx;
    logic [TAG_W-1:0] cur_tag;
    tlb_entry_t       commit_entry, hit_entry;
    logic [VPN_W-1:0] keep_mask;

    tlb_walk_regs #(.IDX_W(IDX_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .miss         (lk_valid && !raw_hit),
        .miss_vpn     (lk_ea[WORD_W-1:OFF_W]),
        .cur_tag      (cur_tag),
        .commit       (commit),
        .commit_idx   (commit_idx),
        .commit_entry (commit_entry),
        .pending      (walk_pending)
    );

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_idx    (commit_idx),
        .wr_entry  (commit_entry),
        .lk_vpn    (lk_ea[WORD_W-1:OFF_W]),
        .lk_tag    (cur_tag),
        .hit       (raw_hit),
        .hit_idx   (lk_idx),
        .hit_entry (hit_entry)
    );

    assign keep_mask = cmp_mask(hit_entry.size);
    assign lk_hit    = lk_valid && raw_hit;
    assign lk_pa     = {(hit_entry.rpn & keep_mask) | (lk_ea[WORD_W-1:OFF_W] & ~keep_mask),
                        lk_ea[OFF_W-1:0]};
    assign lk_attr   = {hit_entry.grp, hit_entry.guarded, hit_entry.wthru};

    // R5: a 4 KB hit keeps the page offset and the full real page
    p_pa_4k_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && hit_entry.size == PS_4K) |->
            (lk_pa[31:12] == hit_entry.rpn && lk_pa[11:0] == lk_ea[11:0]));

endmodule

// File: tb/sim_tlb_reload_unit.sv
`timescale 1ns/100ps
module sim_tlb_reload_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_hit;
    logic [4:0]  lk_idx;
    logic [31:0] lk_pa;
    logic [5:0]  lk_attr;
    logic        walk_pending;

    int checks = 0;
    int fails  = 0;

    logic        s_hit;
    logic [4:0]  s_idx;
    logic [31:0] s_pa;
    logic [5:0]  s_attr;
    logic [31:0] rv;

    always #2 clk = ~clk;

    tlb_reload_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa),
        .lk_attr(lk_attr), .walk_pending(walk_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    // sample a lookup between edges; keep=1 leaves the request up across the next edge
    task automatic look(input logic [31:0] ea, input bit keep);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea;
        #0.5;
        s_hit = lk_hit; s_idx = lk_idx; s_pa = lk_pa; s_attr = lk_attr;
        if (!keep) lk_valid = 1'b0;
    endtask

    task automatic load(input int idx, input logic [31:0] page, input logic [31:0] l2,
                        input logic [31:0] rp);
        wr(3'd0, 32'h0400_0000 | (idx << 8));
        wr(3'd2, page);
        wr(3'd4, l2);
        wr(3'd5, rp);
    endtask

    function automatic logic [19:0] vpn_of(input int i);
        return 20'h10000 + 20'(i * 3);
    endfunction

    function automatic logic [19:0] rpn_of(input int i);
        return 20'h80000 ^ 20'(i * 17);
    endfunction

    function automatic logic [31:0] pa_of(input logic [19:0] rpn, input int lowbits,
                                          input logic [31:0] ea);
        logic [31:0] m;
        m = (32'hFFFF_FFFF << lowbits);
        return ({rpn, 12'b0} & m) | (ea & ~m);
    endfunction

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] miss_ea, exp_page;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1
        rd(3'd0, rv);
        check("R1 ctrl reset", rv, 32'h0400_0000);
        check("R1 pending reset", {31'b0, walk_pending}, 32'd0);
        look(32'h1000_0000, 0);
        check("R1 no hit after reset", {31'b0, s_hit}, 32'd0);

        // R2
        wr(3'd1, 32'hFFFF_FFF7);
        rd(3'd1, rv);
        check("R2 tag reg low bits only", rv, 32'h7);
        wr(3'd3, 32'h1234_5678);
        rd(3'd3, rv);
        check("R2 base write visible", rv & 32'hFFFF_F000, 32'h1234_5000);
        wr(3'd1, 32'h3);

        // R3 sweep: every slot gets its own page
        for (int i = 0; i < 32; i++)
            load(i, {vpn_of(i), 12'h203}, 32'h0000_0001, {rpn_of(i), 12'h0});
        for (int i = 0; i < 32; i++) begin
            logic [31:0] ea;
            ea = {vpn_of(i), 12'(i * 37)};
            look(ea, 0);
            check("R3 sweep hit", {31'b0, s_hit}, 32'd1);
            check("R3 sweep index", {27'b0, s_idx}, i);
            check("R3 sweep pa", s_pa, {rpn_of(i), ea[11:0]});
        end

        // R3 attributes: group 0xA, guarded, write-through
        load(3, {vpn_of(3), 12'h203}, 32'h0000_0153, {rpn_of(3), 12'h0});
        look({vpn_of(3), 12'h0}, 0);
        check("R3 attr", {26'b0, s_attr}, 32'b101011);

        // R4 tag mismatch
        wr(3'd1, 32'h5);
        look({vpn_of(0), 12'h0}, 0);
        check("R4 tag mismatch misses", {31'b0, s_hit}, 32'd0);
        wr(3'd1, 32'h3);
        // R4 entry-valid clear, segment-valid clear
        load(31, {vpn_of(31), 12'h003}, 32'h0000_0001, {rpn_of(31), 12'h0});
        look({vpn_of(31), 12'h0}, 0);
        check("R4 entry-valid clear", {31'b0, s_hit}, 32'd0);
        load(30, {vpn_of(30), 12'h203}, 32'h0000_0000, {rpn_of(30), 12'h0});
        look({vpn_of(30), 12'h0}, 0);
        check("R4 segment-valid clear", {31'b0, s_hit}, 32'd0);

        // R5 8 MB in slot 0
        load(0, {20'h40800, 12'h203}, 32'h0000_000D, 32'hA5F0_0000);
        look(32'h40A5_6789, 0);
        check("R5 8M hit", {31'b0, s_hit}, 32'd1);
        check("R5 8M pa", s_pa, pa_of(20'hA5F00, 23, 32'h40A5_6789));
        look(32'h4100_0000, 0);
        check("R5 8M outside", {31'b0, s_hit}, 32'd0);
        // R5 512 KB in slot 1
        load(1, {20'h20080, 12'h203}, 32'h0000_0005, 32'h1234_5000);
        look(32'h2009_F123, 0);
        check("R5 512K hit", {31'b0, s_hit}, 32'd1);
        check("R5 512K pa", s_pa, pa_of(20'h12345, 19, 32'h2009_F123));
        look(32'h2010_0000, 0);
        check("R5 512K outside", {31'b0, s_hit}, 32'd0);

        // R6 priority
        load(9, {20'h77777, 12'h203}, 32'h1, 32'h9999_9000);
        load(5, {20'h77777, 12'h203}, 32'h1, 32'h5555_5000);
        look(32'h7777_7abc, 0);
        check("R6 lowest index", {27'b0, s_idx}, 32'd5);
        load(5, {20'h77777, 12'h003}, 32'h1, 32'h5555_5000);
        look(32'h7777_7abc, 0);
        check("R6 next index after drop", {27'b0, s_idx}, 32'd9);

        // R11 same-cycle commit vs lookup: slot 9 is the current hit
        wr(3'd0, 32'h0400_0000 | (9 << 8));
        wr(3'd2, {20'h77777, 12'h203});
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'd5; reg_wdata = 32'hCCCC_C000;
        lk_valid = 1'b1; lk_ea = 32'h7777_7001;
        #0.5;
        check("R11 old contents same cycle", lk_pa, 32'h9999_9001);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #0.5;
        check("R11 new contents next cycle", lk_pa, 32'hCCCC_C001);
        lk_valid = 1'b0;

        // R12 replacement
        load(2, {20'h55555, 12'h203}, 32'h1, 32'h0000_1000);
        look({vpn_of(2), 12'h0}, 0);
        check("R12 old page gone", {31'b0, s_hit}, 32'd0);
        look(32'h5555_5000, 0);
        check("R12 new page index", {27'b0, s_idx}, 32'd2);

        // R7 capture
        miss_ea = 32'hDEAD_B123;
        look(miss_ea, 1);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R7 pending set", {31'b0, walk_pending}, 32'd1);
        exp_page = {miss_ea[31:12], 12'h203};
        rd(3'd2, rv);
        check("R7 page captured", rv, exp_page);
        look(32'h1234_5000, 1);
        @(negedge clk);
        lk_valid = 1'b0;
        rd(3'd2, rv);
        check("R7 second miss ignored", rv, exp_page);

        // R9 first-level descriptor address
        wr(3'd3, 32'h0ABC_D000);
        rd(3'd3, rv);
        check("R9 l1 address", rv, 32'h0ABC_D000 | ((miss_ea >> 22) << 2));

        // R10 second-level descriptor address, assist on then off
        wr(3'd4, 32'h0123_4001);
        rd(3'd4, rv);
        check("R10 l2 address", rv, 32'h0123_4000 + (((miss_ea >> 12) & 32'h3FF) << 2));
        wr(3'd0, 32'h0000_0000 | (12 << 8));
        rd(3'd4, rv);
        check("R10 assist off raw", rv, 32'h0123_4001);

        // R8 commit ends the walk and the new entry translates
        wr(3'd5, 32'h6660_0000);
        check("R8 pending cleared", {31'b0, walk_pending}, 32'd0);
        look(miss_ea, 0);
        check("R8 reloaded index", {27'b0, s_idx}, 32'd12);
        check("R8 reloaded pa", s_pa, 32'h6660_0123);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule